// File: doc/BRIEF.md
# SLC-96 Transmit Data Link Inserter

This block drives the signaling-framing bit slots of a DS1 transmit stream with a repeating 36-bit data link sequence. Each sequence opens with a fixed 5-bit marker, carries 24 host-supplied D bits, and closes with a fixed 7-bit marker. One sequence bit goes out per Fs slot (every second frame), so a whole sequence spans 72 frames, about 9 ms. An external frame aligner supplies a superframe-start pulse that realigns the sequence, and an Fs-slot strobe that marks where each bit is sent.

The host loads the D bits through a small register port clocked by the processor clock. Writing the last stack word marks the stack as pending. A toggle handshake carries that request into the line clock domain. At the first slot of the next sequence, the line side takes a snapshot of the stack and acknowledges it. The acknowledge clears the pending flag and raises a stack-empty interrupt, which tells the host it may load again. If nothing new has been loaded, the previous D bits are sent again unchanged. The interrupt is cleared either by reading status or by writing a 1 to it, depending on a select input.

When insertion is off, the Fs output follows a bypass input, and the sequence position is held at its start.

Top module: `slc_dl_tx`

## Requirements
- R1: While insertion is enabled, the bits on successive Fs slots are sequence positions 0..35: positions 0-4 carry 0,0,1,1,1; positions 5-28 carry the D bits; positions 29-35 carry 0,0,0,1,1,1,0. fs_out takes the new bit in the line clock cycle after the slot strobe.
- R2: D bit k (k=0 sent first) is bit 15-k of host word 0 for k<16 (C1..C11, M1..M3, A1..A2) and bit 23-k of host word 1 for k>=16 (S1..S4, SB1..SB4 in bits 7..0).
- R3: The sequence position advances by one only on an Fs-slot strobe while enabled, and wraps from 35 to 0.
- R4: A superframe-start pulse forces the position to 0, so the next Fs slot carries position 0. The pulse has priority over a slot strobe in the same cycle.
- R5: At a position-0 slot, a pending stack is latched and used for that sequence. With no pending stack, the previously latched D bits are sent again, and no interrupt is raised.
- R6: A host write to word 1 (address 1) sets the pending flag (status bit 1), which clears once the line side has latched the stack.
- R7: Latching a stack sets the stack-empty interrupt (status bit 0, also the irq output).
- R8: With clr_on_rd=1, a host read of status (address 2) clears the interrupt. With clr_on_rd=0, reads leave it set, and writing 1 to status bit 0 clears it.
- R9: With insertion disabled, fs_out equals fs_bypass, the position is held at 0, and re-enabling starts at position 0.
- R10: Word 1 bits 15..8 hold no D bits and read back as 0, whatever was written to them.
- R11: After reset, status and both stack words read 0, and the D bits sent before any load are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Processor clock |
| hrst | input | 1 | Synchronous reset, processor domain |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (for clear-on-read) |
| h_addr | input | 2 | 0 = D word 0, 1 = D word 1, 2 = status |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for h_addr |
| clr_on_rd | input | 1 | 1 = status clears on read, 0 = clears on write of 1 |
| irq | output | 1 | Stack-empty interrupt |
| lclk | input | 1 | Line clock |
| lrst | input | 1 | Synchronous reset, line domain |
| ins_en | input | 1 | Insertion enable |
| sf_start | input | 1 | Superframe-start pulse from the aligner |
| fs_slot | input | 1 | Fs bit slot strobe |
| fs_bypass | input | 1 | Fs bit used when insertion is off |
| fs_out | output | 1 | Transmitted Fs bit |

## Verification
The bench targets the sequence edges. It checks the wrap from position 35 to 0, a superframe pulse that arrives mid-sequence, and disabling and re-enabling part way through; a design with a stray counter offset would shift every marker bit. It uses two asymmetric stack patterns, so that a reversed or word-swapped D order shows up as wrong bits. A full sequence with no reload confirms retransmission without a new interrupt. Both interrupt clearing modes are exercised, which catches a clear applied in the wrong mode or an interrupt left set.

// File: rtl/slc_dl_pkg.sv
package slc_dl_pkg;

    localparam int HW        = 16;
    localparam int D_BITS    = 24;
    localparam int LO_BITS   = D_BITS - HW;
    localparam int LEAD_LEN  = 5;
    localparam int TRAIL_LEN = 7;
    localparam int SEQ_LEN   = LEAD_LEN + D_BITS + TRAIL_LEN;
    localparam int SEQ_W     = $clog2(SEQ_LEN);
    localparam int LEAD_IW   = $clog2(LEAD_LEN);
    localparam int TRAIL_IW  = $clog2(TRAIL_LEN);
    localparam int D_IW      = $clog2(D_BITS);
    localparam int SYNC_STAGES = 2;

    // first-sent bit is the MSB
    localparam logic [LEAD_LEN-1:0]  LEAD_PAT  = 5'b00111;
    localparam logic [TRAIL_LEN-1:0] TRAIL_PAT = 7'b0001110;

    typedef logic [SEQ_W-1:0]  seq_pos_t;
    typedef logic [D_BITS-1:0] dstack_t;

    typedef enum logic [1:0] {
        A_WORD_HI = 2'd0,
        A_WORD_LO = 2'd1,
        A_STATUS  = 2'd2
    } haddr_e;

    typedef struct packed {
        logic pending;
        logic empty_irq;
    } hstat_t;

    function automatic logic seq_bit(input seq_pos_t pos, input dstack_t d);
        int p;
        p = int'(pos);
        if (p < LEAD_LEN)
            return LEAD_PAT[LEAD_IW'(LEAD_LEN - 1 - p)];
        else if (p < LEAD_LEN + D_BITS)
            return d[D_IW'(D_BITS - 1 - (p - LEAD_LEN))];
        else
            return TRAIL_PAT[TRAIL_IW'(SEQ_LEN - 1 - p)];
    endfunction

endpackage

// File: rtl/slc_dl_sync.sv
module slc_dl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/slc_dl_host_if.sv
module slc_dl_host_if
    import slc_dl_pkg::*;
(
    input  logic          hclk,
    input  logic          hrst,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [1:0]    h_addr,
    input  logic [HW-1:0] h_wdata,
    output logic [HW-1:0] h_rdata,
    input  logic          clr_on_rd,
    output logic          irq,
    output dstack_t       stack,
    output logic          req_tgl,
    input  logic          ack_tgl
);
    logic [HW-1:0]      word_hi;
    logic [LO_BITS-1:0] word_lo;
    hstat_t             st;
    logic               ack_q, ack_d, ack_evt;

    slc_dl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(hclk), .rst(hrst), .d(ack_tgl), .q(ack_q)
    );

    assign ack_evt = ack_q ^ ack_d;

    always_ff @(posedge hclk) begin
        if (hrst) begin
            word_hi <= '0;
            word_lo <= '0;
            st      <= '0;
            req_tgl <= 1'b0;
            ack_d   <= 1'b0;
        end else begin
            ack_d <= ack_q;
            if (h_wr) begin
                case (h_addr)
                    A_WORD_HI: word_hi <= h_wdata;
                    A_WORD_LO: begin
                        word_lo <= h_wdata[LO_BITS-1:0];
                        if (!st.pending) begin
                            st.pending <= 1'b1;
                            req_tgl    <= ~req_tgl;
                        end
                    end
                    A_STATUS: if (!clr_on_rd && h_wdata[0]) st.empty_irq <= 1'b0;
                    default: ;
                endcase
            end
            if (h_rd && h_addr == A_STATUS && clr_on_rd)
                st.empty_irq <= 1'b0;
            if (ack_evt) begin
                st.pending   <= 1'b0;
                st.empty_irq <= 1'b1;
            end
        end
    end

    always_comb begin
        case (h_addr)
            A_WORD_HI: h_rdata = word_hi;
            A_WORD_LO: h_rdata = {{(HW-LO_BITS){1'b0}}, word_lo};
            A_STATUS:  h_rdata = {{(HW-2){1'b0}}, st.pending, st.empty_irq};
            default:   h_rdata = '0;
        endcase
    end

    assign stack = {word_hi, word_lo};
    assign irq   = st.empty_irq;

    // R7 / R6: returned acknowledge raises the interrupt and drops pending
    p_ack_sets_irq_r7: assert property (@(posedge hclk) disable iff (hrst)
        ack_evt |=> (st.empty_irq && !st.pending));
    // R6: loading the last word leaves the stack pending
    p_load_pending_r6: assert property (@(posedge hclk) disable iff (hrst)
        (h_wr && h_addr == A_WORD_LO && !ack_evt) |=> st.pending);
    // R8: clear-on-read mode clears the interrupt
    p_cor_clears_r8: assert property (@(posedge hclk) disable iff (hrst)
        (h_rd && h_addr == A_STATUS && clr_on_rd && !ack_evt) |=> !st.empty_irq);
    // R8: with clear-on-read off, a read alone keeps the interrupt
    p_read_keeps_r8: assert property (@(posedge hclk) disable iff (hrst)
        (st.empty_irq && !clr_on_rd && !h_wr) |=> st.empty_irq);
endmodule

// File: rtl/slc_dl_line_tx.sv
module slc_dl_line_tx
    import slc_dl_pkg::*;
(
    input  logic    lclk,
    input  logic    lrst,
    input  logic    ins_en,
    input  logic    sf_start,
    input  logic    fs_slot,
    input  logic    fs_bypass,
    input  logic    req_tgl,
    input  dstack_t stack,
    output logic    ack_tgl,
    output logic    fs_out
);
    logic     req_q;
    seq_pos_t pos;
    dstack_t  cur;
    logic     fs_reg;
    logic     pending, take, at_start, at_last;
    dstack_t  d_now;

    slc_dl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(lclk), .rst(lrst), .d(req_tgl), .q(req_q)
    );

    assign pending  = req_q ^ ack_tgl;
    assign at_start = (pos == '0);
    assign at_last  = (pos == seq_pos_t'(SEQ_LEN - 1));
    assign take     = ins_en && fs_slot && !sf_start && at_start && pending;
    assign d_now    = take ? stack : cur;

    always_ff @(posedge lclk) begin
        if (lrst) begin
            pos     <= '0;
            cur     <= '0;
            fs_reg  <= 1'b0;
            ack_tgl <= 1'b0;
        end else if (!ins_en) begin
            pos    <= '0;
            fs_reg <= 1'b0;
        end else if (sf_start) begin
            pos <= '0;
        end else if (fs_slot) begin
            fs_reg <= seq_bit(pos, d_now);
            pos    <= at_last ? '0 : pos + 1'b1;
            if (take) begin
                cur     <= stack;
                ack_tgl <= req_q;
            end
        end
    end

    assign fs_out = ins_en ? fs_reg : fs_bypass;

    // R3: position stays inside the sequence and wraps at its end
    p_pos_range_r3: assert property (@(posedge lclk) disable iff (lrst)
        pos < seq_pos_t'(SEQ_LEN));
    p_wrap_r3: assert property (@(posedge lclk) disable iff (lrst)
        (ins_en && !sf_start && fs_slot && at_last) |=> (pos == '0));
    p_hold_r3: assert property (@(posedge lclk) disable iff (lrst)
        (ins_en && !sf_start && !fs_slot) |=> $stable(pos));
    // R4: superframe start realigns
    p_sf_realign_r4: assert property (@(posedge lclk) disable iff (lrst)
        (ins_en && sf_start) |=> (pos == '0));
    // R9: idle while disabled
    p_idle_r9: assert property (@(posedge lclk) disable iff (lrst)
        !ins_en |=> (pos == '0));
    // R5: acknowledge only answers a pending request at the sequence start
    p_ack_pending_r5: assert property (@(posedge lclk) disable iff (lrst)
        !$stable(ack_tgl) |-> ($past(pending) && $past(pos) == '0));
endmodule

// File: rtl/slc_dl_tx.sv
module slc_dl_tx
    import slc_dl_pkg::*;
(
    input  logic          hclk,
    input  logic          hrst,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [1:0]    h_addr,
    input  logic [HW-1:0] h_wdata,
    output logic [HW-1:0] h_rdata,
    input  logic          clr_on_rd,
    output logic          irq,
    input  logic          lclk,
    input  logic          lrst,
    input  logic          ins_en,
    input  logic          sf_start,
    input  logic          fs_slot,
    input  logic          fs_bypass,
    output logic          fs_out
);
    dstack_t stack;
    logic    req_tgl, ack_tgl;

    slc_dl_host_if u_host (
        .hclk(hclk), .hrst(hrst), .h_wr(h_wr), .h_rd(h_rd),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .clr_on_rd(clr_on_rd), .irq(irq), .stack(stack),
        .req_tgl(req_tgl), .ack_tgl(ack_tgl)
    );

    slc_dl_line_tx u_line (
        .lclk(lclk), .lrst(lrst), .ins_en(ins_en), .sf_start(sf_start),
        .fs_slot(fs_slot), .fs_bypass(fs_bypass), .req_tgl(req_tgl),
        .stack(stack), .ack_tgl(ack_tgl), .fs_out(fs_out)
    );
endmodule

// File: tb/test_slc_dl_tx.sv
`timescale 1ns/1ps
module test_slc_dl_tx;
    logic        hclk = 0, hrst = 1, h_wr = 0, h_rd = 0, clr_on_rd = 0, irq;
    logic [1:0]  h_addr = 0;
    logic [15:0] h_wdata = 0, h_rdata;
    logic        lclk = 0, lrst = 1, ins_en = 0, sf_start = 0, fs_slot = 0;
    logic        fs_bypass = 0, fs_out;

    int vectors = 0, miscompares = 0, wd = 0;
    int m_pos = 0, ph = 0;
    logic m_fs = 0, m_pend = 0, gen_en = 0, sf_req = 0;
    logic [23:0] m_cur = 0;
    logic [15:0] m_hi = 0;
    logic [7:0]  m_lo = 0;
    string req_tag = "R9";
    logic [15:0] rd;

    slc_dl_tx i_slc_dl_tx (
        .hclk(hclk), .hrst(hrst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .clr_on_rd(clr_on_rd), .irq(irq),
        .lclk(lclk), .lrst(lrst), .ins_en(ins_en), .sf_start(sf_start),
        .fs_slot(fs_slot), .fs_bypass(fs_bypass), .fs_out(fs_out)
    );

    always #10 lclk = ~lclk;   // 50 MHz line clock
    always #17 hclk = ~hclk;   // processor clock

    function automatic logic ref_bit(int p, logic [23:0] d);
        if (p == 2 || p == 3 || p == 4) return 1'b1;
        if (p < 5) return 1'b0;
        if (p < 29) return d[23 - (p - 5)];
        if (p == 32 || p == 33 || p == 34) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // slot / superframe generator
    always @(negedge lclk) begin
        if (!lrst) begin
            ph = (ph + 1) % 8;
            fs_slot = gen_en && ph == 0;
            sf_start = sf_req && ph == 4;
            if (sf_start) sf_req = 0;
        end
    end

    // reference model
    always @(posedge lclk) begin
        if (lrst) begin
            m_pos = 0; m_fs = 0; m_cur = 0;
        end else if (!ins_en) begin
            m_pos = 0; m_fs = 0;
        end else if (sf_start) begin
            m_pos = 0;
        end else if (fs_slot) begin
            if (m_pos == 0 && m_pend) begin
                m_cur = {m_hi, m_lo};
                m_pend = 0;
            end
            m_fs = ref_bit(m_pos, m_cur);
            m_pos = (m_pos + 1) % 36;
        end
    end

    // per-cycle compare, away from the edges
    always @(negedge lclk) begin
        #5;
        if (!lrst) begin
            logic e;
            e = ins_en ? m_fs : fs_bypass;
            vectors++;
            if (fs_out !== e) begin
                miscompares++;
                $display("FAIL %s fs_out pos %0d: got %b expected %b", req_tag, m_pos, fs_out, e);
            end
        end
    end

    always @(posedge lclk) begin
        wd++;
        if (wd > 150000) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic hwrite(logic [1:0] a, logic [15:0] d);
        @(negedge hclk);
        h_wr = 1; h_addr = a; h_wdata = d;
        @(negedge hclk);
        h_wr = 0;
        if (a == 2'd0) m_hi = d;
        if (a == 2'd1) begin m_lo = d[7:0]; m_pend = 1; end
    endtask

    task automatic hread(logic [1:0] a, output logic [15:0] d);
        @(negedge hclk);
        h_rd = 1; h_addr = a;
        #1 d = h_rdata;
        @(negedge hclk);
        h_rd = 0;
    endtask

    task automatic wait_pos(int p);
        do @(negedge lclk); while (m_pos != p);
    endtask

    initial begin
        repeat (6) @(negedge hclk);
        hrst = 0;
        @(negedge lclk); lrst = 0;
        // R11: reset state
        hread(2'd2, rd); check("R11 status", rd, 16'h0000);
        hread(2'd0, rd); check("R11 word0", rd, 16'h0000);
        hread(2'd1, rd); check("R11 word1", rd, 16'h0000);
        check("R11 irq", {15'b0, irq}, 16'h0000);
        // R9: bypass while disabled
        req_tag = "R9";
        for (int i = 0; i < 20; i++) begin
            @(negedge lclk); fs_bypass = i[1] ^ i[0];
        end
        @(negedge lclk); fs_bypass = 0; ins_en = 1; gen_en = 1; sf_req = 1;
        // R1/R11: zero stack sequence, R3 wrap
        req_tag = "R1 R3 R11";
        wait_pos(30); wait_pos(10);
        // R2/R6: load a stack
        req_tag = "R1 R2 R5";
        hwrite(2'd0, 16'hA5C3);
        hwrite(2'd1, 16'h005A);
        hread(2'd2, rd); check("R6 pending", rd, 16'h0002);
        wait_pos(0); wait_pos(3);
        hread(2'd2, rd); check("R7 irq after latch", rd, 16'h0001);
        check("R7 irq pin", {15'b0, irq}, 16'h0001);
        // R8: write-1 clear mode
        clr_on_rd = 0;
        hread(2'd2, rd); check("R8 read keeps", rd, 16'h0001);
        hwrite(2'd2, 16'h0001);
        hread(2'd2, rd); check("R8 w1c", rd, 16'h0000);
        // R5: retransmission without reload
        wait_pos(0); wait_pos(5); wait_pos(0); wait_pos(5);
        hread(2'd2, rd); check("R5 no new irq", rd, 16'h0000);
        // R10: upper byte of word 1
        wait_pos(8);
        hwrite(2'd0, 16'h1234);
        hwrite(2'd1, 16'hFF96);
        hread(2'd1, rd); check("R10 word1 upper", rd, 16'h0096);
        clr_on_rd = 1;
        wait_pos(0); wait_pos(3);
        hread(2'd2, rd); check("R8 cor first read", rd, 16'h0001);
        hread(2'd2, rd); check("R8 cor cleared", rd, 16'h0000);
        // R4: superframe start mid-sequence
        req_tag = "R4";
        wait_pos(15);
        sf_req = 1;
        wait_pos(0); wait_pos(4);
        check("R4 realigned pos", 16'(m_pos), 16'd4);
        wait_pos(20);
        // R9: disable mid-sequence and resume from the start
        req_tag = "R9";
        @(negedge lclk); ins_en = 0; fs_bypass = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge lclk); fs_bypass = i[2];
        end
        @(negedge lclk); ins_en = 1;
        req_tag = "R9 R1";
        wait_pos(6);
        wait_pos(0);
        repeat (4) @(negedge lclk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule